// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This unit carries out single-bit operations on a byte for a small processor core. Each request brings an opcode, the 8-bit operand, two possible bit-number sources (a 3-bit immediate and a register value), a select between them, and the current carry (C) and zero (Z) flags. One cycle later the unit presents the new operand value, the new flag values, and a write-enable strobe for the operand, for C and for Z. The core uses these strobes to decide what to write back.

Six operations exist. Four of them accept either index source:
- set a bit,
- clear a bit,
- invert a bit,
- test a bit, which loads Z with the complement of the bit.

The other two update only C. One ANDs C with the bit, the other ANDs C with the complement of the bit. These two accept only the immediate index. A request that selects the register index for them, or that uses an unassigned opcode, raises an illegal-combination output and writes nothing.

A two-state controller gates the strobes. State IDLE is entered on reset, and from any state when an edge sees no valid request. State ISSUE is entered from any state when an edge sees a valid request. In ISSUE the captured strobes are driven. In IDLE they are held low.

Top module: `bitop_unit`

## Requirements
- R1: A synchronous active-high reset clears result_o, c_o, z_o, all three write strobes and illegal_o to 0 at the next rising edge.
- R2: Outputs reflect the request sampled at the rising edge where in_valid_i is 1, visible after that edge. After an edge with in_valid_i at 0, all strobes and illegal_o are 0, and result_o, c_o and z_o keep their values.
- R3: Opcode 0 (set) gives result_o equal to the operand with the selected bit forced to 1. It asserts only opnd_we_o, and c_o and z_o equal the input flags.
- R4: Opcode 1 (clear) forces the selected bit to 0. It asserts only opnd_we_o, and the flags pass through.
- R5: Opcode 2 (invert) complements the selected bit. It asserts only opnd_we_o, and the flags pass through.
- R6: Opcode 3 (test) leaves result_o equal to the operand and sets z_o to the complement of the selected bit. It asserts only z_we_o, and c_o passes through.
- R7: Opcode 4 (carry AND) sets c_o to c_i AND the selected bit. It asserts only c_we_o, result_o equals the operand, and z_o passes through.
- R8: Opcode 5 (carry AND inverse) sets c_o to c_i AND NOT the selected bit. It asserts only c_we_o, result_o equals the operand, and z_o passes through.
- R9: With idx_src_reg_i at 0 the bit number is imm_idx_i. With it at 1 the bit number is reg_idx_i[2:0], and bits 7:3 of reg_idx_i have no effect. Register indexing applies to opcodes 0 to 3.
- R10: Opcode 4 or 5 with idx_src_reg_i at 1 sets illegal_o to 1 and asserts no write strobe. result_o equals the operand, and the flags pass through.
- R11: Opcodes 6 and 7 behave as illegal in the same way as R10.
- R12: At most one of opnd_we_o, c_we_o, z_we_o and illegal_o is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Request present this cycle |
| op_i | input | 3 | Operation code (0 set, 1 clear, 2 invert, 3 test, 4 carry AND, 5 carry AND inverse) |
| operand_i | input | 8 | Byte operand |
| imm_idx_i | input | 3 | Immediate bit number |
| reg_idx_i | input | 8 | Register value whose low 3 bits give the bit number |
| idx_src_reg_i | input | 1 | 1 selects the register bit number, 0 the immediate |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| result_o | output | 8 | Operand after the operation |
| c_o | output | 1 | New carry value |
| z_o | output | 1 | New zero value |
| opnd_we_o | output | 1 | Write back result_o |
| c_we_o | output | 1 | Write back c_o |
| z_we_o | output | 1 | Write back z_o |
| illegal_o | output | 1 | Request was an illegal combination |

## Verification
The hardest case to reach is a register index whose upper five bits disagree with the low three. A unit that wrongly used more of the register would pick another bit or none at all, and a normal request would never show this. The stimulus pairs register values such as 0xF9 and 0x5A with operands where the bit named by the low three bits differs from its neighbours. It also drives back-to-back valid requests and a reset that arrives together with a valid request, so the controller's state changes are covered from every state.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SET   = 3'd0,
        OP_CLR   = 3'd1,
        OP_INV   = 3'd2,
        OP_TST   = 3'd3,
        OP_CAND  = 3'd4,
        OP_CANDN = 3'd5
    } bop_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } st_e;

    typedef struct packed {
        logic we_d;
        logic we_c;
        logic we_z;
        logic bad;
    } strobe_t;

endpackage

// File: rtl/bitop_index.sv
module bitop_index
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [IDX_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] regv_i,
    input  logic              src_reg_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              legal_o
);

    logic op_known;
    logic op_carry;

    always_comb begin
        op_known = (op_i <= OP_W'(OP_CANDN));
        op_carry = (op_i == OP_W'(OP_CAND)) || (op_i == OP_W'(OP_CANDN));
        // only the low index bits of the register take part
        idx_o    = src_reg_i ? regv_i[IDX_W-1:0] : imm_i;
        legal_o  = op_known && !(op_carry && src_reg_i);
    end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              legal_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic [DATA_W-1:0] data_o,
    output logic              c_o,
    output logic              z_o,
    output strobe_t           stb_o
);

    logic [DATA_W-1:0] sel_mask;
    logic              bit_val;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign sel_mask[gi] = (idx_i == IDX_W'(gi));
    end

    assign bit_val = |(opnd_i & sel_mask);

    always_comb begin
        data_o = opnd_i;
        c_o    = c_i;
        z_o    = z_i;
        stb_o  = '0;
        if (!legal_i) begin
            stb_o.bad = 1'b1;
        end else begin
            unique case (bop_e'(op_i))
                OP_SET: begin
                    data_o     = opnd_i | sel_mask;
                    stb_o.we_d = 1'b1;
                end
                OP_CLR: begin
                    data_o     = opnd_i & ~sel_mask;
                    stb_o.we_d = 1'b1;
                end
                OP_INV: begin
                    data_o     = opnd_i ^ sel_mask;
                    stb_o.we_d = 1'b1;
                end
                OP_TST: begin
                    z_o        = ~bit_val;
                    stb_o.we_z = 1'b1;
                end
                OP_CAND: begin
                    c_o        = c_i & bit_val;
                    stb_o.we_c = 1'b1;
                end
                OP_CANDN: begin
                    c_o        = c_i & ~bit_val;
                    stb_o.we_c = 1'b1;
                end
                default: stb_o.bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  imm_idx_i,
    input  logic [DATA_W-1:0] reg_idx_i,
    input  logic              idx_src_reg_i,
    input  logic              c_i,
    input  logic              z_i,
    output logic [DATA_W-1:0] result_o,
    output logic              c_o,
    output logic              z_o,
    output logic              opnd_we_o,
    output logic              c_we_o,
    output logic              z_we_o,
    output logic              illegal_o
);

    logic [IDX_W-1:0]  idx_w;
    logic              legal_w;
    logic [DATA_W-1:0] data_w;
    logic              c_w, z_w;
    strobe_t           stb_w, stb_q, stb_out;
    st_e               st_q, st_d;

    bitop_index #(.DATA_W(DATA_W)) u_index (
        .op_i      (op_i),
        .imm_i     (imm_idx_i),
        .regv_i    (reg_idx_i),
        .src_reg_i (idx_src_reg_i),
        .idx_o     (idx_w),
        .legal_o   (legal_w)
    );

    bitop_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i    (op_i),
        .opnd_i  (operand_i),
        .idx_i   (idx_w),
        .legal_i (legal_w),
        .c_i     (c_i),
        .z_i     (z_i),
        .data_o  (data_w),
        .c_o     (c_w),
        .z_o     (z_w),
        .stb_o   (stb_w)
    );

    // next state: ISSUE after any valid edge, IDLE otherwise
    always_comb begin
        st_d = in_valid_i ? ST_ISSUE : ST_IDLE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_IDLE;
        else       st_q <= st_d;
    end

    // captured data and strobes
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            result_o <= '0;
            c_o      <= 1'b0;
            z_o      <= 1'b0;
            stb_q    <= '0;
        end else if (in_valid_i) begin
            result_o <= data_w;
            c_o      <= c_w;
            z_o      <= z_w;
            stb_q    <= stb_w;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_ISSUE: stb_out = stb_q;
            ST_IDLE:  stb_out = '0;
            default:  stb_out = '0;
        endcase
    end

    assign opnd_we_o = stb_out.we_d;
    assign c_we_o    = stb_out.we_c;
    assign z_we_o    = stb_out.we_z;
    assign illegal_o = stb_out.bad;

    // ---------------- assertions ----------------
    assert_rst_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (result_o == '0 && !c_o && !z_o && !opnd_we_o && !c_we_o && !z_we_o && !illegal_o));

    assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> (!opnd_we_o && !c_we_o && !z_we_o && !illegal_o && $stable(result_o)));

    assert_set_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == OP_W'(OP_SET) && !idx_src_reg_i) |=>
        (opnd_we_o && result_o == ($past(operand_i) | (DATA_W'(1) << $past(imm_idx_i)))));

    assert_tst_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == OP_W'(OP_TST) && !idx_src_reg_i) |=>
        (z_we_o && z_o == !$past(operand_i[imm_idx_i]) && result_o == $past(operand_i)));

    assert_cand_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == OP_W'(OP_CAND) && !idx_src_reg_i) |=>
        (c_we_o && c_o == ($past(c_i) && $past(operand_i[imm_idx_i]))));

    assert_regidx_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && op_i == OP_W'(OP_INV) && idx_src_reg_i) |=>
        (result_o == ($past(operand_i) ^ (DATA_W'(1) << $past(reg_idx_i[IDX_W-1:0])))));

    assert_illegal_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && idx_src_reg_i && op_i >= OP_W'(OP_CAND)) |=>
        (illegal_o && !opnd_we_o && !c_we_o && !z_we_o));

    assert_one_strobe_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({opnd_we_o, c_we_o, z_we_o, illegal_o}));

endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;

    localparam int CLK_P = 10;
    localparam int NVEC  = 18;

    logic       clk, rst, in_valid;
    logic [2:0] op, imm;
    logic [7:0] opnd, regv;
    logic       src, c_in, z_in;
    logic [7:0] result;
    logic       c_out, z_out, we_d, we_c, we_z, ill;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bitop_unit #(.DATA_W(8)) u0 (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .op_i(op),
        .operand_i(opnd), .imm_idx_i(imm), .reg_idx_i(regv),
        .idx_src_reg_i(src), .c_i(c_in), .z_i(z_in),
        .result_o(result), .c_o(c_out), .z_o(z_out),
        .opnd_we_o(we_d), .c_we_o(we_c), .z_we_o(we_z), .illegal_o(ill)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    // {op, operand, imm, reg, src, c, z}
    localparam logic [24:0] VEC [NVEC] = '{
        {3'd0, 8'hA4, 3'd0, 8'h00, 1'b0, 1'b1, 1'b1},
        {3'd0, 8'h00, 3'd7, 8'h00, 1'b0, 1'b0, 1'b0},
        {3'd1, 8'hFF, 3'd3, 8'h00, 1'b0, 1'b1, 1'b0},
        {3'd1, 8'h10, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1},
        {3'd2, 8'h55, 3'd0, 8'h00, 1'b0, 1'b0, 1'b0},
        {3'd2, 8'h55, 3'd1, 8'h00, 1'b0, 1'b1, 1'b1},
        {3'd3, 8'h02, 3'd1, 8'h00, 1'b0, 1'b1, 1'b0},
        {3'd3, 8'hFD, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0},
        {3'd4, 8'h80, 3'd7, 8'h00, 1'b0, 1'b1, 1'b0},
        {3'd4, 8'h7F, 3'd7, 8'h00, 1'b0, 1'b1, 1'b1},
        {3'd4, 8'hFF, 3'd2, 8'h00, 1'b0, 1'b0, 1'b0},
        {3'd5, 8'h08, 3'd3, 8'h00, 1'b0, 1'b1, 1'b0},
        {3'd5, 8'hF7, 3'd3, 8'h00, 1'b0, 1'b1, 1'b1},
        {3'd0, 8'h00, 3'd0, 8'hF9, 1'b1, 1'b0, 1'b0},
        {3'd3, 8'h04, 3'd2, 8'h5A, 1'b1, 1'b1, 1'b1},
        {3'd4, 8'hFF, 3'd1, 8'h01, 1'b1, 1'b1, 1'b0},
        {3'd6, 8'h3C, 3'd2, 8'h00, 1'b0, 1'b1, 1'b1},
        {3'd7, 8'hC3, 3'd5, 8'h00, 1'b0, 1'b0, 1'b1}
    };

    // returns {bad, we_d, we_c, we_z, c, z, data[7:0]}
    function automatic logic [13:0] model(input logic [2:0] o, input logic [7:0] d,
                                          input logic [2:0] im, input logic [7:0] rv,
                                          input logic s, input logic ci, input logic zi);
        logic [2:0] k;
        logic b;
        logic [7:0] r;
        logic co, zo, wd, wc, wz, il;
        k = s ? rv[2:0] : im;
        b = d[k];
        r = d; co = ci; zo = zi; wd = 0; wc = 0; wz = 0; il = 0;
        if (o > 3'd5 || (s && o >= 3'd4)) il = 1;
        else case (o)
            3'd0: begin r[k] = 1'b1; wd = 1; end
            3'd1: begin r[k] = 1'b0; wd = 1; end
            3'd2: begin r[k] = ~b;   wd = 1; end
            3'd3: begin zo = ~b;     wz = 1; end
            3'd4: begin co = ci & b;  wc = 1; end
            default: begin co = ci & ~b; wc = 1; end
        endcase
        return {il, wd, wc, wz, co, zo, r};
    endfunction

    function automatic string tag_of(input logic [2:0] o, input logic s);
        if (o > 3'd5) return "R11";
        if (s && o >= 3'd4) return "R10";
        if (s) return "R9";
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [24:0] v);
        {op, opnd, imm, regv, src, c_in, z_in} = v;
        in_valid = 1'b1;
    endtask

    task automatic check_out(input logic [24:0] v, input string tag);
        logic [13:0] e;
        e = model(v[24:22], v[21:14], v[13:11], v[10:3], v[2], v[1], v[0]);
        chk(tag, "result", {24'd0, result}, {24'd0, e[7:0]});
        chk(tag, "flags",  {30'd0, c_out, z_out}, {30'd0, e[9:8]});
        chk(tag, "strobes", {28'd0, ill, we_d, we_c, we_z}, {28'd0, e[13:10]});
        chk("R12", "onehot", {31'd0, $onehot0({ill, we_d, we_c, we_z})}, 32'd1);
    endtask

    initial begin
        logic [7:0] held;
        rst = 1'b1; in_valid = 1'b0;
        {op, opnd, imm, regv, src, c_in, z_in} = '0;
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", {22'd0, result, c_out, z_out, we_d, we_c, we_z, ill}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check_out(VEC[i], tag_of(VEC[i][24:22], VEC[i][2]));
        end

        // R2: idle edge clears strobes and holds data
        drive({3'd2, 8'h0F, 3'd4, 8'h00, 1'b0, 1'b1, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        held = result;
        opnd = 8'h00; op = 3'd1;
        @(negedge clk);
        chk("R2", "idle strobes", {28'd0, ill, we_d, we_c, we_z}, 32'd0);
        chk("R2", "idle hold", {24'd0, result}, {24'd0, held});
        chk("R2", "idle flags", {30'd0, c_out, z_out}, {30'd0, 2'b10});

        // R2: back-to-back valid requests
        drive({3'd3, 8'h00, 3'd6, 8'h00, 1'b0, 1'b0, 1'b0});
        @(negedge clk);
        check_out({3'd3, 8'h00, 3'd6, 8'h00, 1'b0, 1'b0, 1'b0}, "R2");
        drive({3'd5, 8'h00, 3'd6, 8'h00, 1'b0, 1'b1, 1'b1});
        @(negedge clk);
        in_valid = 1'b0;
        check_out({3'd5, 8'h00, 3'd6, 8'h00, 1'b0, 1'b1, 1'b1}, "R2");

        // R9: only upper register bits change, same bit picked
        drive({3'd2, 8'h00, 3'd0, 8'hF9, 1'b1, 1'b0, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "upper reg bits ignored", {24'd0, result}, 32'h02);

        // R1: reset wins over a valid request
        drive({3'd0, 8'h11, 3'd2, 8'h00, 1'b0, 1'b1, 1'b1});
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "reset over valid", {22'd0, result, c_out, z_out, we_d, we_c, we_z, ill}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule